// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block records processor activity into a 64-line, 20-bit circular store. An arm/trigger sequencer controls it. Software arms the block with a one-cycle `arm_set` pulse. Each activity record arrives as a 20-bit word qualified by `rec_valid`. The `trig` input marks the moment the external match logic reaches its final state.

Two alignments are supported, selected by `align_begin`:

- **End alignment:** records are kept from arming until the trigger, and the trigger closes the session.
- **Begin alignment:** nothing is kept until the trigger. From the trigger on, exactly 64 lines are captured, and then the session closes.

When a session closes, the arm flag drops and an optional one-cycle breakpoint request is raised. With tracing disabled, the trigger alone closes the session.

After a session, software drains the buffer through a 16-bit window. Each line takes two word reads, upper word first, and the lines come out oldest first.

Top module: `trace_capture_buf`

## Requirements
- R1: A pulse on `arm_set` while disarmed raises `armed` on the next edge and clears the store count, the full flag and the write pointer. A pulse on `arm_set` while armed has no effect.
- R2: With end alignment (`align_begin`=0) and tracing on, each record with `rec_valid` high before the trigger is stored at the write pointer. A trigger drops `armed` on the next edge, and the record presented in the trigger cycle is not stored.
- R3: With begin alignment, no record is stored before the trigger. Records are stored from the trigger cycle onward, inclusive. The block stays armed until the 64th line is stored and disarms on that same edge.
- R4: A record presented while `halt` is high is never stored.
- R5: Writes wrap from line 63 to line 0. `store_cnt` increments once per stored line and saturates at 64. `full` rises on the edge where the count reaches 64.
- R6: When a session ends, `brk_req` pulses for exactly one cycle if `brk_en` is high, and not at all otherwise. With `trace_en` low, the trigger alone ends the session; with both enables low, the trigger just disarms.
- R7: At session end the read pointer moves to the oldest line: line 0 if `full` is low, else the next write position. `rd_hi` returns `{12'b0, line[19:16]}` and `rd_lo` returns `line[15:0]`. The pointer advances by one line, modulo 64, only on an `rd_lo` that follows an `rd_hi`. `rd_data` is 0 when no read strobe is high.
- R8: While armed, `rd_data` reads as 0 under any read strobe, and reads neither move the read pointer nor count as a high-word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_set | input | 1 | Arm request pulse |
| align_begin | input | 1 | 1: capture starts at trigger; 0: capture ends at trigger |
| trace_en | input | 1 | Tracing enabled |
| brk_en | input | 1 | Breakpoint request enabled |
| trig | input | 1 | Final-state trigger |
| halt | input | 1 | Debug halt, suppresses capture |
| rec_valid | input | 1 | Activity record strobe |
| rec_data | input | 20 | Activity record |
| rd_hi | input | 1 | Read upper word of current line |
| rd_lo | input | 1 | Read lower word of current line |
| rd_data | output | 16 | Read window data |
| armed | output | 1 | Arm flag |
| brk_req | output | 1 | Breakpoint request pulse |
| store_cnt | output | 7 | Lines stored this session (saturating) |
| full | output | 1 | Buffer has been filled |

## Verification
The end-aligned case uses a short burst that contains a halted record, a trigger-cycle record and a repeated arm pulse. This separates what is stored from what is dropped. An end-aligned run of 70 records distinguishes a correct wrap and oldest-first readout from a pointer that restarts at zero. A begin-aligned run feeds pre-trigger noise and then exactly 64 post-trigger records, which pins down the cycle of disarm and of the breakpoint pulse. Runs with tracing off, and with both enables off, separate the breakpoint-only path from a silent disarm. Armed reads and lone low-word reads show that the read pointer moves only on a completed line.

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 20,
  parameter int WORD  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_set,
  input  logic             align_begin,
  input  logic             trace_en,
  input  logic             brk_en,
  input  logic             trig,
  input  logic             halt,
  input  logic             rec_valid,
  input  logic [WIDTH-1:0] rec_data,
  input  logic             rd_hi,
  input  logic             rd_lo,
  output logic [WORD-1:0]  rd_data,
  output logic             armed,
  output logic             brk_req,
  output logic [$clog2(DEPTH+1)-1:0] store_cnt,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int HW = WIDTH - WORD;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, ptr_n;
  logic             post, hi_done;
  logic             store, last, end_sess, full_n;

  assign wr_nxt = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;

  assign store = armed && trace_en && rec_valid && !halt &&
                 (post || (align_begin ? trig : !trig));

  assign last     = store && align_begin && (store_cnt == CW'(DEPTH-1));
  assign end_sess = armed && ((trig && !post && (!trace_en || !align_begin)) || last);
  assign full_n   = full || (store && store_cnt == CW'(DEPTH-1));
  assign ptr_n    = store ? wr_nxt : wr_ptr;

  always_ff @(posedge clk)
    if (store) mem[wr_ptr] <= rec_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      post      <= 1'b0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      store_cnt <= '0;
      full      <= 1'b0;
      hi_done   <= 1'b0;
      brk_req   <= 1'b0;
    end else begin
      brk_req <= end_sess && brk_en;
      if (!armed) begin
        if (arm_set) begin
          armed     <= 1'b1;
          post      <= 1'b0;
          wr_ptr    <= '0;
          store_cnt <= '0;
          full      <= 1'b0;
          hi_done   <= 1'b0;
        end else if (rd_hi) begin
          hi_done <= 1'b1;
        end else if (rd_lo && hi_done) begin
          rd_ptr  <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
          hi_done <= 1'b0;
        end
      end else begin
        if (store) begin
          wr_ptr <= wr_nxt;
          if (store_cnt != CW'(DEPTH)) store_cnt <= store_cnt + 1'b1;
        end
        full <= full_n;
        if (trig && align_begin && trace_en && !post) post <= 1'b1;
        if (end_sess) begin
          armed   <= 1'b0;
          post    <= 1'b0;
          hi_done <= 1'b0;
          rd_ptr  <= full_n ? ptr_n : '0;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (!armed) begin
      if (rd_hi)      rd_data = WORD'(mem[rd_ptr][WIDTH-1:WORD]);
      else if (rd_lo) rd_data = mem[rd_ptr][WORD-1:0];
    end
  end

  logic unused_hw;
  assign unused_hw = (HW == 0);
endmodule

module trace_capture_buf_chk #(parameter int DEPTH = 64, parameter int CW = 7, parameter int AW = 6) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm_set,
  input logic          halt,
  input logic          brk_en,
  input logic          armed,
  input logic          brk_req,
  input logic          full,
  input logic [CW-1:0] store_cnt,
  input logic [AW-1:0] rd_ptr
);
  AST_ARM_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n)
    (arm_set && !armed) |=> (armed && store_cnt == '0 && !full)); // R1
  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm_set) |=> $stable(store_cnt)); // R2
  AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !(arm_set && !armed)) |=> $stable(store_cnt)); // R4
  AST_CNT_LIMIT:    assert property (@(posedge clk) disable iff (!rst_n)
    store_cnt <= CW'(DEPTH)); // R5
  AST_FULL_AT_MAX:  assert property (@(posedge clk) disable iff (!rst_n)
    full |-> store_cnt == CW'(DEPTH)); // R5
  AST_BRK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req); // R6
  AST_BRK_ENABLED:  assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> ($past(brk_en) && !armed)); // R6
  AST_RD_FROZEN:    assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> $stable(rd_ptr)); // R8
endmodule

bind trace_capture_buf trace_capture_buf_chk #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .halt(halt), .brk_en(brk_en),
  .armed(armed), .brk_req(brk_req), .full(full), .store_cnt(store_cnt), .rd_ptr(rd_ptr));

// File: tb/sim_trace_capture_buf.sv
module sim_trace_capture_buf;
  logic clk = 0, rst_n = 0;
  logic arm_set = 0, align_begin = 0, trace_en = 1, brk_en = 1, trig = 0, halt = 0;
  logic rec_valid = 0, rd_hi = 0, rd_lo = 0;
  logic [19:0] rec_data = '0;
  logic [15:0] rd_data;
  logic armed, brk_req, full;
  logic [6:0] store_cnt;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  trace_capture_buf u0 (.*);

  function automatic logic [19:0] rec(int i);
    return 20'h12345 + 20'(i) * 20'h0A3B5;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(logic [19:0] d, bit v, bit h, bit t);
    rec_data = d; rec_valid = v; halt = h; trig = t;
    tick();
    rec_valid = 0; halt = 0; trig = 0;
  endtask

  task automatic do_arm();
    arm_set = 1; tick(); arm_set = 0;
  endtask

  task automatic read_line(output logic [19:0] line);
    logic [15:0] hi;
    rd_hi = 1; #1 hi = rd_data; tick(); rd_hi = 0;
    rd_lo = 1; #1 line = {hi[3:0], rd_data}; tick(); rd_lo = 0;
  endtask

  task automatic t_reset();
    chk(!armed && !brk_req && store_cnt == 0 && !full, "R1 reset", {armed, brk_req, full}, 0);
    chk(rd_data == 0, "R7 idle window", rd_data, 0);
  endtask

  task automatic t_end_align();
    logic [19:0] l;
    align_begin = 0; trace_en = 1; brk_en = 1;
    do_arm();
    chk(armed && store_cnt == 0, "R1 arm", store_cnt, 0);
    rd_hi = 1; #1 chk(rd_data == 0, "R8 armed read", rd_data, 0); tick(); rd_hi = 0;
    rd_lo = 1; #1 chk(rd_data == 0, "R8 armed read lo", rd_data, 0); tick(); rd_lo = 0;
    for (int i = 0; i < 3; i++) push(rec(i), 1, 0, 0);
    push(20'hFFFFF, 1, 1, 0);
    chk(store_cnt == 3, "R4 halt", store_cnt, 3);
    for (int i = 3; i < 5; i++) push(rec(i), 1, 0, 0);
    do_arm();
    chk(armed && store_cnt == 5, "R1 rearm ignored", store_cnt, 5);
    push(20'hABCDE, 1, 0, 1);
    chk(!armed && brk_req && store_cnt == 5, "R2 trigger end", {armed, brk_req}, 1);
    tick();
    chk(!brk_req, "R6 pulse width", brk_req, 0);
    rd_lo = 1; tick(); rd_lo = 0;
    for (int i = 0; i < 5; i++) begin
      read_line(l);
      chk(l == rec(i), "R7 R8 readout", l, rec(i));
    end
  endtask

  task automatic t_wrap();
    logic [19:0] l;
    int bad = 0;
    align_begin = 0; trace_en = 1; brk_en = 0;
    do_arm();
    for (int i = 0; i < 63; i++) push(rec(100 + i), 1, 0, 0);
    chk(!full && store_cnt == 63, "R5 not full", store_cnt, 63);
    push(rec(163), 1, 0, 0);
    chk(full && store_cnt == 64, "R5 full", store_cnt, 64);
    for (int i = 64; i < 70; i++) push(rec(100 + i), 1, 0, 0);
    chk(store_cnt == 64, "R5 saturate", store_cnt, 64);
    push(0, 0, 0, 1);
    chk(!armed && !brk_req, "R6 no brk when disabled", brk_req, 0);
    for (int i = 0; i < 64; i++) begin
      read_line(l);
      if (l != rec(106 + i)) bad++;
    end
    chk(bad == 0, "R5 R7 wrap oldest first", bad, 0);
  endtask

  task automatic t_begin_align();
    logic [19:0] l;
    int bad = 0;
    align_begin = 1; trace_en = 1; brk_en = 1;
    do_arm();
    for (int i = 0; i < 3; i++) push(rec(500 + i), 1, 0, 0);
    chk(armed && store_cnt == 0, "R3 pre-trigger", store_cnt, 0);
    push(rec(200), 1, 0, 1);
    chk(armed && store_cnt == 1, "R3 trigger stored", store_cnt, 1);
    for (int i = 1; i < 63; i++) push(rec(200 + i), 1, 0, 0);
    chk(armed && !brk_req && store_cnt == 63, "R3 still armed", store_cnt, 63);
    push(rec(263), 1, 0, 0);
    chk(!armed && brk_req && store_cnt == 64 && full, "R3 R6 end at 64", {armed, brk_req}, 1);
    for (int i = 0; i < 64; i++) begin
      read_line(l);
      if (l != rec(200 + i)) bad++;
    end
    chk(bad == 0, "R3 R7 readout", bad, 0);
  endtask

  task automatic t_no_trace();
    align_begin = 0; trace_en = 0; brk_en = 1;
    do_arm();
    for (int i = 0; i < 3; i++) push(rec(i), 1, 0, 0);
    chk(store_cnt == 0, "R6 no trace stores", store_cnt, 0);
    push(0, 0, 0, 1);
    chk(!armed && brk_req, "R6 brk only", {armed, brk_req}, 1);
  endtask

  task automatic t_neither();
    trace_en = 0; brk_en = 0;
    do_arm();
    chk(armed, "R1 arm neither", armed, 1);
    push(0, 0, 0, 1);
    chk(!armed && !brk_req, "R6 silent disarm", {armed, brk_req}, 0);
    tick();
    chk(!brk_req, "R6 silent disarm later", brk_req, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_end_align();
    t_wrap();
    t_begin_align();
    t_no_trace();
    t_neither();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule